// File: doc/BRIEF.md
# Time-multiplexed single-multiplier FIR filter

This block computes a finite impulse response filter when input samples arrive far more slowly than the system clock. All taps share one hardware multiplier. A single-cycle strobe marks each new sample. The sample goes into a circular history memory that holds `NTAPS` entries. The block then spends one clock per tap forming a product of a stored sample and a coefficient, and sums the products. At the end of the pass it presents the total together with a one-cycle result strobe, so a following stage can use the same clock-enable convention.

Coefficients are loaded at run time through a write strobe and a data word. Each write lands at an internal index, which then advances. The history memory and the coefficient memory are both read through a registered port with one cycle of latency and nothing else done on the read value, so both map onto block RAM. A small controller with two states steps the read addresses. In `ST_IDLE` it waits for a sample. An accepted strobe moves it to `ST_RUN`. In `ST_RUN` it issues one read pair per clock, with the history address rising from the oldest sample and the coefficient address falling from the last entry. It returns to `ST_IDLE` once it has issued the read for coefficient entry 0. Reset forces `ST_IDLE` from either state. The history write index has no reset. To clear the filter, hold reset and the sample strobe high while feeding zeros for `NTAPS` clocks.

Top module: `fir_tdm_mac`

## Requirements
- R1: While `rst` is high, `result` is 0 and `result_stb` is low. A pass in progress is abandoned and produces no result. The coefficient write index returns to entry 0.
- R2: The history memory holds `NTAPS` entries, and its write index advances by one per stored sample, wrapping from `NTAPS-1` to 0. The result for each accepted sample is sum over k of h[k]*x[n-k], taken over that sample and the `NTAPS-1` accepted samples before it. This holds for runs longer than `NTAPS` samples.
- R3: Coefficient entry k multiplies the sample accepted k strobes earlier. Entry 0 therefore weights the newest sample. After a cleared history, an input of 1 followed by zeros yields entries 0, 1, ..., `NTAPS-1` in that order.
- R4: Each `coef_we` cycle writes `coef_in` into the entry at the coefficient write index, and the index then advances by one. After entry `NTAPS-1` it wraps to entry 0.
- R5: `result_stb` is high for exactly one cycle. It rises `NTAPS+2` rising edges after the edge that accepted the sample, and `result` is valid in that same cycle.
- R6: With `rst` low, a `sample_stb` seen in `ST_RUN` is ignored: nothing is written, the write index does not move, and no result follows from it. Strobes 1 to `NTAPS` edges after an accepted one fall in this window.
- R7: A strobe `NTAPS+1` edges after the previous accepted one is accepted, and both results are correct.
- R8: With `rst` high, each edge with `sample_stb` high writes `sample_in` and advances the write index. No pass starts and no result strobe appears.
- R9: The result width `DW+CW+ceil(log2(NTAPS))` holds the sum of `NTAPS` products of most-negative operands without wrapping. Products are sign-extended before they are accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | New-sample strobe, one cycle per sample |
| sample_in | input | DW | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_in | input | CW | Signed coefficient word |
| result | output | DW+CW+ceil(log2(NTAPS)) | Signed filter output |
| result_stb | output | 1 | One-cycle strobe marking a new result |

## Verification
A corrupted history write index or a misplaced read start shows up at the first result after the fault. That result pairs coefficients with the wrong samples, so an impulse yields the coefficients out of order. A wrong pass length or a missing first-product load shows in the very next result: its value either carries over the previous total or drops a tap, and the result strobe moves away from `NTAPS+2` edges after the sample. A controller that accepts strobes while busy produces an extra result strobe within `NTAPS+2` cycles. It also leaves a stray sample in the history, which corrupts the results of the following `NTAPS` samples.

// File: rtl/fir_tdm_pkg.sv
package fir_tdm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pass_state_t;

    function automatic int addr_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fir_sample_ring.sv
module fir_sample_ring #(
    parameter  int NTAPS = 7,
    parameter  int DW    = 12,
    localparam int AW    = fir_tdm_pkg::addr_bits(NTAPS)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] wr_idx
);
    localparam logic [AW-1:0] LAST = AW'(NTAPS - 1);

    logic [DW-1:0] mem [NTAPS];
    // no reset on the write index: the history is flushed by feeding zeros
    logic [AW-1:0] idx = '0;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= wr_data;
            idx      <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

    // plain registered read so the array maps onto block RAM
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end

    assign wr_idx = idx;

endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
    parameter  int NTAPS = 7,
    parameter  int CW    = 12,
    localparam int AW    = fir_tdm_pkg::addr_bits(NTAPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_data
);
    localparam logic [AW-1:0] LAST = AW'(NTAPS - 1);

    logic [CW-1:0] mem [NTAPS];
    logic [AW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (wr_en) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= wr_data;
        end
        rd_data <= mem[rd_addr];
    end

    // R1: a reset always brings the load pointer back to entry 0
    p_coef_idx_home_r1: assert property (@(posedge clk) rst |=> (idx == '0))
        else $error("coefficient write index not home after reset");

endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
    parameter  int DW = 12,
    parameter  int CW = 12,
    parameter  int OW = 27,
    localparam int PW = DW + CW,
    localparam int GW = OW - PW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic                 in_first,
    input  logic                 in_last,
    input  logic signed [DW-1:0] din,
    input  logic signed [CW-1:0] cin,
    output logic signed [OW-1:0] acc_out,
    output logic                 out_stb
);
    logic signed [PW-1:0] prod;
    logic signed [OW-1:0] prod_x;
    logic signed [OW-1:0] acc;
    logic                 p_vld, p_first, p_last;

    // the single shared multiplier
    always_ff @(posedge clk) begin
        prod <= din * cin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_vld   <= 1'b0;
            p_first <= 1'b0;
            p_last  <= 1'b0;
        end else begin
            p_vld   <= in_vld;
            p_first <= in_first;
            p_last  <= in_last;
        end
    end

    assign prod_x = {{GW{prod[PW-1]}}, prod};

    // the first product of a pass loads the accumulator, clearing the old total
    always_ff @(posedge clk) begin
        if (p_vld) begin
            acc <= p_first ? prod_x : acc + prod_x;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_out <= '0;
            out_stb <= 1'b0;
        end else begin
            out_stb <= p_vld && p_last;
            if (p_vld && p_last) begin
                acc_out <= (p_first ? '0 : acc) + prod_x;
            end
        end
    end

    // R5: a result strobe never lasts two cycles
    p_out_single_r5: assert property (@(posedge clk) disable iff (rst)
        out_stb |=> !out_stb)
        else $error("result strobe longer than one cycle");

endmodule

// File: rtl/fir_tdm_mac.sv
module fir_tdm_mac #(
    parameter  int NTAPS = 7,
    parameter  int DW    = 12,
    parameter  int CW    = 12,
    localparam int AW    = fir_tdm_pkg::addr_bits(NTAPS),
    localparam int OW    = DW + CW + $clog2(NTAPS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_stb,
    input  logic signed [DW-1:0] sample_in,
    input  logic                 coef_we,
    input  logic signed [CW-1:0] coef_in,
    output logic signed [OW-1:0] result,
    output logic                 result_stb
);
    import fir_tdm_pkg::*;

    localparam logic [AW-1:0] LAST = AW'(NTAPS - 1);

    pass_state_t          st, st_nx;
    logic [AW-1:0]        dptr, cptr, wr_idx;
    logic                 take, ring_we;
    logic                 r_vld, r_first, r_last;
    logic signed [DW-1:0] d_rd;
    logic signed [CW-1:0] c_rd;

    assign take    = sample_stb && !rst && (st == ST_IDLE);
    // during reset the strobe still stores samples: this is the flush path
    assign ring_we = sample_stb && (rst || (st == ST_IDLE));

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (take)        st_nx = ST_RUN;
            ST_RUN:  if (cptr == '0)  st_nx = ST_IDLE;
        endcase
    end

    // read addresses and the flags that travel with each read
    always_ff @(posedge clk) begin
        if (rst) begin
            dptr    <= '0;
            cptr    <= '0;
            r_vld   <= 1'b0;
            r_first <= 1'b0;
            r_last  <= 1'b0;
        end else begin
            r_vld   <= (st == ST_RUN);
            r_first <= (st == ST_RUN) && (cptr == LAST);
            r_last  <= (st == ST_RUN) && (cptr == '0);
            unique case (st)
                ST_IDLE: if (take) begin
                    // after this write the oldest sample sits one past it
                    dptr <= (wr_idx == LAST) ? '0 : wr_idx + 1'b1;
                    cptr <= LAST;
                end
                ST_RUN: begin
                    dptr <= (dptr == LAST) ? '0 : dptr + 1'b1;
                    cptr <= cptr - 1'b1;
                end
            endcase
        end
    end

    fir_sample_ring #(.NTAPS(NTAPS), .DW(DW)) u_ring (
        .clk     (clk),
        .wr_en   (ring_we),
        .wr_data (sample_in),
        .rd_addr (dptr),
        .rd_data (d_rd),
        .wr_idx  (wr_idx)
    );

    fir_coef_bank #(.NTAPS(NTAPS), .CW(CW)) u_coef (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (coef_we),
        .wr_data (coef_in),
        .rd_addr (cptr),
        .rd_data (c_rd)
    );

    fir_mac #(.DW(DW), .CW(CW), .OW(OW)) u_mac (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (r_vld),
        .in_first (r_first),
        .in_last  (r_last),
        .din      (d_rd),
        .cin      (c_rd),
        .acc_out  (result),
        .out_stb  (result_stb)
    );

    // R6: a strobe during a pass leaves the history write index untouched
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && sample_stb) |=> (wr_idx == $past(wr_idx)))
        else $error("sample accepted while a pass was running");

    // R2: the write index stays inside the history depth
    p_widx_range_r2: assert property (@(posedge clk) disable iff (rst)
        wr_idx <= LAST)
        else $error("history write index out of range");

    // R7: the last read of a pass is always followed by an idle read slot
    p_read_gap_r7: assert property (@(posedge clk) disable iff (rst)
        (r_vld && r_last) |=> !r_vld)
        else $error("read burst overran the end of a pass");

endmodule

// File: tb/test_fir_tdm_mac.sv
`timescale 1ns/1ps
module test_fir_tdm_mac;
    localparam int N  = 7;
    localparam int IW = 12;
    localparam int CW = 12;
    localparam int OW = IW + CW + $clog2(N);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                 rst, sample_stb, coef_we;
    logic signed [IW-1:0] sample_in;
    logic signed [CW-1:0] coef_in;
    logic signed [OW-1:0] result;
    logic                 result_stb;

    fir_tdm_mac #(.NTAPS(N), .DW(IW), .CW(CW)) i_fir_tdm_mac (
        .clk(clk), .rst(rst), .sample_stb(sample_stb), .sample_in(sample_in),
        .coef_we(coef_we), .coef_in(coef_in), .result(result), .result_stb(result_stb)
    );

    localparam logic signed [IW-1:0] VEC [12] = '{
        12'sd100, -12'sd37, 12'sd2047, -12'sd2048, 12'sd0, 12'sd511,
        -12'sd1, 12'sd300, -12'sd900, 12'sd77, 12'sd1234, -12'sd5 };
    localparam logic signed [CW-1:0] H1 [N] = '{
        12'sd5, -12'sd3, 12'sd17, 12'sd250, -12'sd90, 12'sd8, 12'sd1 };
    localparam logic signed [CW-1:0] H2 [N] = '{
        -12'sd7, 12'sd20, 12'sd33, -12'sd1, 12'sd4, 12'sd2, -12'sd100 };

    int  cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    longint obuf [64];
    int     ocyc [64];
    int     ocnt = 0, perr = 0;
    bit     pv = 1'b0;
    always @(negedge clk) begin
        if (result_stb && ocnt < 64) begin
            obuf[ocnt] = longint'(result);
            ocyc[ocnt] = cyc;
            ocnt++;
        end
        if (result_stb && pv) perr++;
        pv = result_stb;
    end

    int ncmp = 0, nfail = 0;
    logic signed [IW-1:0] hist [N];
    logic signed [CW-1:0] hcur [N];

    function automatic longint model();
        longint s = 0;
        for (int k = 0; k < N; k++) s += longint'(hcur[k]) * longint'(hist[k]);
        return s;
    endfunction

    function automatic void push(input logic signed [IW-1:0] x);
        for (int k = N - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        ncmp++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic signed [IW-1:0] x, output int c);
        @(negedge clk);
        sample_stb = 1'b1;
        sample_in  = x;
        c = cyc;
        @(negedge clk);
        sample_stb = 1'b0;
        #1;
    endtask

    task automatic expect_out(input int idx, input longint exp, input int c, input string tag);
        int t = 0;
        while (ocnt <= idx && t < 100) begin
            @(negedge clk);
            #1;
            t++;
        end
        check(ocnt > idx, {tag, " result present"}, ocnt, idx + 1);
        if (ocnt > idx) begin
            check(obuf[idx] == exp, tag, obuf[idx], exp);
            // R5: strobe follows the accepting edge by N+2 edges
            check(ocyc[idx] - c == N + 3, "R5 latency", ocyc[idx] - c, N + 3);
        end
    endtask

    task automatic run(input logic signed [IW-1:0] x, input string tag);
        int b, c;
        b = ocnt;
        send(x, c);
        push(x);
        expect_out(b, model(), c, tag);
    endtask

    task automatic write_coef(input logic signed [CW-1:0] v);
        @(negedge clk);
        coef_we = 1'b1;
        coef_in = v;
        @(negedge clk);
        coef_we = 1'b0;
        #1;
    endtask

    task automatic flush();
        @(negedge clk);
        rst        = 1'b1;
        sample_stb = 1'b1;
        sample_in  = '0;
        repeat (N) @(negedge clk);
        rst        = 1'b0;
        sample_stb = 1'b0;
        for (int k = 0; k < N; k++) hist[k] = '0;
        #1;
    endtask

    initial begin
        #(4 * 200000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
        $finish;
    end

    initial begin
        int b, c1, c2;
        longint ea, eb;
        rst = 1'b1; sample_stb = 1'b0; sample_in = '0; coef_we = 1'b0; coef_in = '0;
        repeat (3) @(negedge clk);
        #1;
        check(result == 0 && !result_stb, "R1 reset state", longint'(result), 0);

        // R8: flush under reset writes zeros without starting a pass
        b = ocnt;
        flush();
        repeat (N + 4) @(negedge clk);
        #1;
        check(ocnt == b, "R8 no result during flush", ocnt - b, 0);

        // R1: partial coefficient load is discarded by reset, full load starts at entry 0
        write_coef(12'sd111); write_coef(12'sd222); write_coef(12'sd333);
        flush();
        for (int k = 0; k < N; k++) begin
            write_coef(H1[k]);
            hcur[k] = H1[k];
        end

        // R3: impulse response comes out as entries 0..N-1
        for (int k = 0; k < N; k++) run((k == 0) ? 12'sd1 : 12'sd0, "R3 impulse order");

        // R2: vector table, longer than the history so the index wraps
        foreach (VEC[i]) run(VEC[i], "R2 vector result");

        // R7: minimum spacing of N+1 edges
        b = ocnt;
        send(12'sd400, c1); push(12'sd400); ea = model();
        repeat (N - 1) @(negedge clk);
        send(-12'sd250, c2); push(-12'sd250); eb = model();
        expect_out(b, ea, c1, "R7 first of close pair");
        expect_out(b + 1, eb, c2, "R7 second of close pair");

        // R6: a strobe N edges after an accepted one is ignored
        b = ocnt;
        send(12'sd60, c1); push(12'sd60); ea = model();
        repeat (N - 2) @(negedge clk);
        send(12'sd1999, c2);
        expect_out(b, ea, c1, "R6 result before ignored strobe");
        repeat (N + 6) @(negedge clk);
        #1;
        check(ocnt == b + 1, "R6 no result from ignored strobe", ocnt - b, 1);
        run(12'sd9, "R6 history without ignored sample");

        // R4: N more writes wrap to entry 0, one extra write replaces entry 0
        for (int k = 0; k < N; k++) begin
            write_coef(H2[k]);
            hcur[k] = H2[k];
        end
        write_coef(12'sd55);
        hcur[0] = 12'sd55;
        flush();
        run(12'sd1, "R4 wrapped write lands on entry 0");
        run(12'sd0, "R4 entry 1 kept");

        // R9: full-scale negative operands
        flush();
        for (int k = 0; k < N; k++) begin
            write_coef(-12'sd2048);
            hcur[k] = -12'sd2048;
        end
        for (int k = 0; k < N; k++) run(-12'sd2048, "R9 full scale sum");
        check(obuf[ocnt-1] == longint'(N) * 4194304, "R9 final full scale",
              obuf[ocnt-1], longint'(N) * 4194304);

        // R1: reset during a pass abandons it
        b = ocnt;
        send(12'sd3, c1);
        repeat (2) @(negedge clk);
        flush();
        repeat (N + 6) @(negedge clk);
        #1;
        check(ocnt == b, "R1 aborted pass gives no result", ocnt - b, 0);
        check(result == 0, "R1 result cleared", longint'(result), 0);

        // R5: every strobe was a single cycle
        check(perr == 0, "R5 strobe width", perr, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
        $finish;
    end

endmodule